// File: doc/BRIEF.md
# Serial Register Access Master

This block lets on-chip logic read and write 32-bit registers in a remote controller over a five-wire bit-serial link. The wires are a serial clock, a data line toward the slave, a data line back from the slave, a commit strobe, and a direction line that is high only while a write is in flight. One request carries a direction flag, a 12-bit register address and, for writes, a 32-bit value. A finished transfer is reported with a one-cycle done pulse, and for reads the collected value comes with it.

Link timing is built from a time unit of `UNIT_CLKS` system clocks. Every edge on the link falls on a unit boundary. A write sends the address, a short gap, the 32 data bits and a second gap, then the commit strobe. A read sends the address and a gap, then the commit strobe, then clocks 32 bits in from the slave. The address and write data leave most-significant bit first. Read data arrives least-significant bit first.

The request side uses valid/ready. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and the fields are sampled on that edge. `req_ready_o` stays low from that edge until the done pulse. While it is low the requester may hold or change its request freely, and nothing it presents has any effect. There is no back-pressure on the result. `done_o` is a single-cycle pulse, and `rdata_o` holds its value until the next read collects new data.

Top module: `serial_reg_master`

## Requirements
- R1: During and after reset the link clock, data-to-slave, commit strobe and direction lines are all low, `done_o` is low and `req_ready_o` is high. Whenever no transfer is in progress, those four link lines stay low.
- R2: A request is accepted on an edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low from that edge until the done pulse. Requests presented while it is low are ignored.
- R3: The transfer begins in the cycle after acceptance with the 12 address bits, most-significant first. Each bit is driven on the data-to-slave line for one unit with the link clock low, then held for one unit with the link clock high.
- R4: For a write, the direction line is high from the first address unit until the end of the commit sequence, and low in the done cycle. For a read, it stays low throughout.
- R5: For a write, the 32 data bits follow most-significant first, three units each: clock low, clock high, clock low, with the bit held on the data line for all three units.
- R6: The data-to-slave line is driven low for one gap unit after the address bits and for one gap unit after the write data. It is low during the commit sequence and during read clocking.
- R7: The commit sequence is 7 units long: strobe high with clock low for 2 units, then strobe and clock both high for 3 units, then both low together for 2 units.
- R8: For a read, the commit sequence follows the address gap directly. It is followed by 32 bit slots of five units each: clock low for 1 unit, clock high for 2 units, then clock low for 2 units. The return line is sampled at the end of the first of those two low units.
- R9: Read bits are assembled least-significant first. The first sampled bit lands in `rdata_o[0]` and the 32nd lands in `rdata_o[31]`.
- R10: `done_o` is high for exactly one cycle, in the first cycle after the last unit, which is 129 units after acceptance for a write and 192 units for a read. In that cycle `rdata_o` holds the value just read, and `req_ready_o` is high again.
- R11: Every link level is held for a whole number of units, and each unit lasts exactly `UNIT_CLKS` system clocks (at least 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle; a request is taken this edge if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Remote register address |
| req_wdata_i | input | 32 | Write value |
| done_o | output | 1 | One-cycle transfer-complete pulse |
| rdata_o | output | 32 | Last value read |
| link_clk_o | output | 1 | Serial clock to slave |
| link_din_o | output | 1 | Serial data to slave |
| link_dout_i | input | 1 | Serial data from slave |
| link_load_o | output | 1 | Commit strobe |
| link_wnr_o | output | 1 | Direction: high during a write |

## Verification
Some properties are checked on every cycle by assertions:
- the link lines are quiet while idle;
- the strobe and the clock drop on the same edge;
- the data line is low whenever the strobe is high;
- the direction line does not change during a transfer;
- `done_o` is a single-cycle pulse;
- the unit counter and step counter stay within range.

Other behaviour depends on the exact order of levels across a whole transfer, and only the bench's scenarios can show it. The bench checks:
- the order of address and data bits on the data line;
- the exact unit lengths of every phase;
- the placement of the read sample point;
- least-significant-first assembly, using asymmetric slave values;
- that requests changed during a busy transfer are ignored.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_GAPA, PH_WDATA, PH_GAPD, PH_COMMIT, PH_RDATA
  } phase_t;

  localparam int ADDR_STEPS   = 2;
  localparam int WDATA_STEPS  = 3;
  localparam int GAP_STEPS    = 1;
  localparam int COMMIT_STEPS = 7;
  localparam int RDATA_STEPS  = 5;
  localparam int RD_SAMPLE_STEP = 3;

  function automatic int steps_of(phase_t p);
    case (p)
      PH_ADDR:   return ADDR_STEPS;
      PH_WDATA:  return WDATA_STEPS;
      PH_COMMIT: return COMMIT_STEPS;
      PH_RDATA:  return RDATA_STEPS;
      default:   return GAP_STEPS;
    endcase
  endfunction
endpackage

// File: rtl/sr_unit_timer.sv
module sr_unit_timer #(
  parameter int UNIT_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_W'(UNIT_CLKS - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_unit_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < UNIT_CLKS);
endmodule

// File: rtl/sr_sequencer.sv
module sr_sequencer import sr_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             start_write_i,
  output phase_t           phase_o,
  output logic [2:0]       step_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             wr_o,
  output logic             finish_o
);
  int   bits_here;
  logic last_step, last_bit;
  phase_t next_phase;

  always_comb begin
    case (phase_o)
      PH_ADDR:            bits_here = ADDR_W;
      PH_WDATA, PH_RDATA: bits_here = DATA_W;
      default:            bits_here = 1;
    endcase
    case (phase_o)
      PH_ADDR:   next_phase = PH_GAPA;
      PH_GAPA:   next_phase = wr_o ? PH_WDATA : PH_COMMIT;
      PH_WDATA:  next_phase = PH_GAPD;
      PH_GAPD:   next_phase = PH_COMMIT;
      PH_COMMIT: next_phase = wr_o ? PH_IDLE : PH_RDATA;
      default:   next_phase = PH_IDLE;
    endcase
  end

  assign last_step = int'(step_o) == steps_of(phase_o) - 1;
  assign last_bit  = int'(bit_o) == bits_here - 1;
  assign finish_o  = tick_i && last_step && last_bit &&
                     ((phase_o == PH_COMMIT && wr_o) || phase_o == PH_RDATA);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_o <= PH_IDLE;
      step_o  <= '0;
      bit_o   <= '0;
      wr_o    <= 1'b0;
    end else if (phase_o == PH_IDLE) begin
      if (start_i) begin
        phase_o <= PH_ADDR;
        wr_o    <= start_write_i;
        step_o  <= '0;
        bit_o   <= '0;
      end
    end else if (tick_i) begin
      if (last_step) begin
        step_o <= '0;
        if (last_bit) begin
          bit_o   <= '0;
          phase_o <= next_phase;
        end else begin
          bit_o <= bit_o + 1'b1;
        end
      end else begin
        step_o <= step_o + 1'b1;
      end
    end
  end

  assert_step_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(step_o) < steps_of(phase_o));
  assert_bit_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(bit_o) < bits_here);
endmodule

// File: rtl/sr_rx_collect.sv
module sr_rx_collect #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);
  // LSB-first arrival: shift right, so the first bit ends at position 0
  always_ff @(posedge clk_i) begin
    if (!rst_ni)       data_o <= '0;
    else if (sample_i) data_o <= {bit_i, data_o[DATA_W-1:1]};
  end
endmodule

// File: rtl/serial_reg_master.sv
module serial_reg_master import sr_pkg::*; #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int UNIT_CLKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              link_clk_o,
  output logic              link_din_o,
  input  logic              link_dout_i,
  output logic              link_load_o,
  output logic              link_wnr_o
);
  localparam int MAX_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int BIT_W = $clog2(MAX_W);

  phase_t           phase;
  logic [2:0]       step;
  logic [BIT_W-1:0] bit_idx;
  logic             wr, tick, finish, accept, sample;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= finish;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  sr_unit_timer #(.UNIT_CLKS(UNIT_CLKS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(!req_ready_o), .tick_o(tick)
  );

  sr_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(accept),
    .start_write_i(req_write_i), .phase_o(phase), .step_o(step),
    .bit_o(bit_idx), .wr_o(wr), .finish_o(finish)
  );

  assign sample = tick && (phase == PH_RDATA) && (int'(step) == RD_SAMPLE_STEP);

  sr_rx_collect #(.DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample), .bit_i(link_dout_i),
    .data_o(rdata_o)
  );

  always_comb begin
    link_clk_o  = 1'b0;
    link_din_o  = 1'b0;
    link_load_o = 1'b0;
    case (phase)
      PH_ADDR: begin
        link_clk_o = (step == 3'd1);
        link_din_o = addr_q[ADDR_W-1-int'(bit_idx)];
      end
      PH_WDATA: begin
        link_clk_o = (step == 3'd1);
        link_din_o = wdata_q[DATA_W-1-int'(bit_idx)];
      end
      PH_COMMIT: begin
        link_load_o = (step < 3'd5);
        link_clk_o  = (step >= 3'd2) && (step < 3'd5);
      end
      PH_RDATA:  link_clk_o = (step == 3'd1) || (step == 3'd2);
      default: ;
    endcase
  end

  assign link_wnr_o = !req_ready_o && wr;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !(link_clk_o || link_din_o || link_load_o || link_wnr_o));
  assert_wnr_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !$past(req_ready_o)) |-> $stable(link_wnr_o));
  assert_din_low_in_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_load_o |-> !link_din_o);
  assert_load_clk_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_load_o) |-> $fell(link_clk_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
endmodule

// File: tb/serial_reg_master_test.sv
module serial_reg_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, done, lclk, ldin, lload, lwnr;
  logic ldout = 1'b0;
  logic [31:0] rdata;

  int checks = 0, errors = 0, cycles = 0;

  logic [4:0] expq[$];   // {clk, din, load, wnr, done}
  string      tagq[$];
  logic [31:0] exp_rdata = '0;
  logic        cur_wr = 1'b0;

  logic [31:0] slave_val = '0;
  logic [63:0] cap = '0;
  int          cap_n = 0, rd_idx = 0;
  logic        rd_on = 1'b0;
  logic [11:0] cur_addr = '0;
  logic [31:0] cur_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_master #(.ADDR_W(12), .DATA_W(32), .UNIT_CLKS(UNIT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata), .link_clk_o(lclk), .link_din_o(ldin),
    .link_dout_i(ldout), .link_load_o(lload), .link_wnr_o(lwnr)
  );

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(int n, bit c, bit d, bit l, bit w, string tag);
    for (int k = 0; k < n * UNIT; k++) begin
      expq.push_back({c, d, l, w, 1'b0});
      tagq.push_back(tag);
    end
  endtask

  task automatic build(bit wr, logic [11:0] a, logic [31:0] d);
    for (int i = 11; i >= 0; i--) begin
      push(1, 0, a[i], 0, wr, "R3");
      push(1, 1, a[i], 0, wr, "R3");
    end
    push(1, 0, 0, 0, wr, "R6");
    if (wr) begin
      for (int i = 31; i >= 0; i--) begin
        push(1, 0, d[i], 0, 1, "R5");
        push(1, 1, d[i], 0, 1, "R5");
        push(1, 0, d[i], 0, 1, "R5");
      end
      push(1, 0, 0, 0, 1, "R6");
    end
    push(2, 0, 0, 1, wr, "R7");
    push(3, 1, 0, 1, wr, "R7");
    push(2, 0, 0, 0, wr, "R7");
    if (!wr) begin
      for (int i = 0; i < 32; i++) begin
        push(1, 0, 0, 0, 0, "R8");
        push(2, 1, 0, 0, 0, "R8");
        push(2, 0, 0, 0, 0, "R8");
      end
    end
    expq.push_back(5'b00001);
    tagq.push_back("R10");
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] e;
      string tg;
      bit busy_exp;
      busy_exp = expq.size() != 0;
      e  = busy_exp ? expq.pop_front() : 5'b0;
      tg = busy_exp ? tagq.pop_front() : "R1";
      check({lclk, ldin, lload, lwnr} == e[4:1], tg, "link pins {clk,din,load,wnr}",
            {lclk, ldin, lload, lwnr}, e[4:1]);
      check(done == e[0], "R10", "done", done, e[0]);
      check(req_ready == (!busy_exp || e[0]), "R2", "ready", req_ready, (!busy_exp || e[0]));
      if (e[0] && !cur_wr) check(rdata == exp_rdata, "R9", "rdata", rdata, exp_rdata);
    end
  end

  // slave model: captures outgoing bits, returns read bits LSB first
  always @(posedge lclk) begin
    if (rd_on) begin
      ldout = slave_val[rd_idx];
      rd_idx++;
      if (rd_idx == 32) rd_on = 1'b0;
    end else if (!lload) begin
      cap = {cap[62:0], ldin};
      cap_n++;
    end
  end

  always @(posedge lload) begin
    if (lwnr) begin
      check(cap_n == 44, "R5", "bits before commit", cap_n, 44);
      check(cap[43:0] == {cur_addr, cur_data}, "R5", "addr+data captured",
            cap[43:0], {cur_addr, cur_data});
    end else begin
      check(cap_n == 12, "R3", "bits before commit", cap_n, 12);
      check(cap[11:0] == cur_addr, "R3", "addr captured", cap[11:0], cur_addr);
    end
  end

  always @(negedge lload) begin
    if (!lwnr) begin
      rd_on  = 1'b1;
      rd_idx = 0;
    end
  end

  task automatic xfer(bit wr, logic [11:0] a, logic [31:0] d, logic [31:0] sv, bit junk);
    @(negedge clk); #1;
    check(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    slave_val = sv; exp_rdata = sv; cur_wr = wr; cur_addr = a; cur_data = d;
    cap_n = 0;
    build(wr, a, d);
    @(negedge clk); #1;
    if (junk) begin
      // R2: new request content held while busy must be ignored
      req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      repeat (40) @(negedge clk);
      #1;
    end
    req_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL R10 watchdog: actual=hang expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({lclk, ldin, lload, lwnr} == 4'b0, "R1", "pins in reset", {lclk, ldin, lload, lwnr}, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(1, 12'hA5C, 32'hDEADBEEF, 32'h0, 0);        // write, R4 R5 R7 R11
    xfer(0, 12'h3F1, 32'h0, 32'h80000001, 0);        // read, R8 R9
    xfer(0, 12'h5A3, 32'h0, 32'h12345678, 1);        // read, busy request ignored R2
    xfer(1, 12'h000, 32'h00000000, 32'h0, 1);        // all-zero write, junk while busy
    xfer(1, 12'hFFF, 32'hFFFFFFFF, 32'h0, 0);        // all-ones write
    xfer(0, 12'h800, 32'h0, 32'hFFFF0000, 0);        // read, upper half set
    check(rdata == 32'hFFFF0000, "R10", "rdata holds after done", rdata, 32'hFFFF0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule